// File: doc/BRIEF.md
# Multicycle Accumulator Processor

A small processor that keeps its program and its data in one shared memory, reached over one address bus and one data bus. Every memory access, whether it fetches an instruction or touches an operand, goes out through the memory address register and comes back through (or leaves from) the memory buffer register. A control unit walks through a fixed sequence of register transfers, one transfer per clock, to fetch an instruction and then carry it out. The only architectural data register is the accumulator D0.

An instruction word has the op-code in its upper half and an operand address in its lower half. With the default 16-bit width that gives an 8-bit op-code and an 8-bit address. The external memory is a synchronous single-port RAM with a one-cycle read latency. The processor runs from address 0 after reset until it reaches a halt instruction. It then freezes and signals the halt until it is reset again.

Top module: `acc_cpu`

## Requirements
- R1: While reset is held and right after it, the bus shows address 0, write enable is low and halted is low. PC, the address register and D0 are all cleared, so the first instruction is fetched from address 0 and a STORE run before any load writes 0.
- R2: Each instruction is read from the address held in the PC, and the PC then moves up by one. Bits [15:8] of the word are the op-code and bits [7:0] are the operand address. The second instruction's address appears on the bus in the 10th cycle after reset is released.
- R3: Op-code 0x01 (ADD) sets D0 to D0 + M[addr], wrapping modulo 2^16.
- R4: Op-code 0x02 (SUB) sets D0 to D0 - M[addr], wrapping modulo 2^16.
- R5: Op-code 0x03 (LOAD) sets D0 to M[addr].
- R6: Op-code 0x04 (STORE) writes D0 to address addr. Write enable is high for exactly one cycle, with memAddr equal to addr and memWdata equal to D0.
- R7: Op-code 0x05 (CLR) sets D0 to 0.
- R8: Op-code 0x06 (JMP) loads the PC with addr. Execution continues there, and the instructions it skips have no effect.
- R9: Op-code 0xFF (HALT) raises halted. After that no write occurs and the bus address stays fixed. Only reset clears halted.
- R10: Any other op-code changes neither D0 nor memory, and execution goes on with the next word.
- R11: Execution takes 8 cycles for ADD, SUB and LOAD, 7 for STORE, and 5 for CLR, JMP and no-op words. Halted rises 5 cycles after a HALT word's fetch begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| memRdata | input | 16 | Read data from memory, valid the cycle after the address |
| memAddr | output | 8 | Memory address, driven from the address register |
| memWdata | output | 16 | Write data, driven from the buffer register |
| memWe | output | 1 | Memory write enable, one cycle per STORE |
| halted | output | 1 | High once a HALT has executed, until reset |

## Verification
The assertions assume that memory answers every address with read data one cycle later and that reset is held for at least one clock edge. The bench's memory model follows that latency exactly and always pulses reset before a program starts. They also assume that the program and data are loaded while reset is asserted, so that no word changes under a running fetch. The bench fills memory only inside reset and keeps data words at addresses that the control flow never reaches.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  typedef enum logic [1:0] {
    ALU_PASS = 2'd0,
    ALU_ADD  = 2'd1,
    ALU_SUB  = 2'd2,
    ALU_ZERO = 2'd3
  } aluOpE;

  // strobes from control to datapath, one register transfer each
  typedef struct packed {
    logic  marFromPc;
    logic  marFromIr;
    logic  pcInc;
    logic  pcLoad;
    logic  mbrFromMem;
    logic  mbrFromD0;
    logic  irLoad;
    logic  d0Load;
    aluOpE aluOp;
    logic  memWe;
  } ctlStrobeS;

  localparam logic [7:0] OPC_ADD   = 8'h01;
  localparam logic [7:0] OPC_SUB   = 8'h02;
  localparam logic [7:0] OPC_LOAD  = 8'h03;
  localparam logic [7:0] OPC_STORE = 8'h04;
  localparam logic [7:0] OPC_CLR   = 8'h05;
  localparam logic [7:0] OPC_JMP   = 8'h06;

endpackage

// File: rtl/acc_alu.sv
module acc_alu
  import acc_cpu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  aluOpE            op,
  output logic [WIDTH-1:0] y
);

  always_comb begin
    unique case (op)
      ALU_ADD:  y = a + b;
      ALU_SUB:  y = a - b;
      ALU_ZERO: y = '0;
      default:  y = b;
    endcase
  end

endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = DATA_W / 2,
  parameter int OPC_W  = DATA_W - ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  ctlStrobeS         ctl,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [OPC_W-1:0]  opcode
);

  logic [ADDR_W-1:0] pc;
  logic [ADDR_W-1:0] mar;
  logic [DATA_W-1:0] mbr;
  logic [DATA_W-1:0] ir;
  logic [DATA_W-1:0] d0;
  logic [DATA_W-1:0] aluY;
  logic [ADDR_W-1:0] irAddr;

  assign irAddr   = ir[ADDR_W-1:0];
  assign opcode   = ir[DATA_W-1 -: OPC_W];
  assign memAddr  = mar;
  assign memWdata = mbr;

  acc_alu #(.WIDTH(DATA_W)) alu (
    .a  (d0),
    .b  (mbr),
    .op (ctl.aluOp),
    .y  (aluY)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc  <= '0;
      mar <= '0;
      mbr <= '0;
      ir  <= '0;
      d0  <= '0;
    end else begin
      if (ctl.marFromPc)       mar <= pc;
      else if (ctl.marFromIr)  mar <= irAddr;
      if (ctl.pcInc)           pc  <= pc + ADDR_W'(1);
      else if (ctl.pcLoad)     pc  <= irAddr;
      if (ctl.mbrFromMem)      mbr <= memRdata;
      else if (ctl.mbrFromD0)  mbr <= d0;
      if (ctl.irLoad)          ir  <= mbr;
      if (ctl.d0Load)          d0  <= aluY;
    end
  end

  // R2: program counter steps by exactly one, wrapping
  a_r2_pc_step: assert property (@(posedge clk) disable iff (rst)
    ctl.pcInc |=> pc == $past(pc) + ADDR_W'(1));

  // R2: instruction register takes the word the buffer held
  a_r2_ir_from_mbr: assert property (@(posedge clk) disable iff (rst)
    ctl.irLoad |=> ir == $past(mbr));

  // R3: addition wraps modulo 2^DATA_W
  a_r3_add_wrap: assert property (@(posedge clk) disable iff (rst)
    (ctl.d0Load && ctl.aluOp == ALU_ADD) |=> d0 == DATA_W'($past(d0) + $past(mbr)));

  // R6: the data written equals the accumulator
  a_r6_store_data: assert property (@(posedge clk) disable iff (rst)
    ctl.memWe |-> memWdata == d0);

endmodule

// File: rtl/acc_control.sv
module acc_control
  import acc_cpu_pkg::*;
#(
  parameter int OPC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] opcode,
  output ctlStrobeS        ctl,
  output logic             halted
);

  typedef enum logic [3:0] {
    S_FETCH_MAR,
    S_FETCH_INC,
    S_FETCH_MBR,
    S_FETCH_IR,
    S_DECODE,
    S_OP_WAIT,
    S_OP_MBR,
    S_OP_ALU,
    S_ST_WRITE,
    S_HALT
  } stateE;

  stateE state, stateNext;

  logic isAdd, isSub, isLoad, isStore, isClr, isJmp, isHalt, isRead;

  assign isAdd   = opcode == OPC_W'(OPC_ADD);
  assign isSub   = opcode == OPC_W'(OPC_SUB);
  assign isLoad  = opcode == OPC_W'(OPC_LOAD);
  assign isStore = opcode == OPC_W'(OPC_STORE);
  assign isClr   = opcode == OPC_W'(OPC_CLR);
  assign isJmp   = opcode == OPC_W'(OPC_JMP);
  assign isHalt  = &opcode;
  assign isRead  = isAdd | isSub | isLoad;

  always_comb begin
    ctl       = '0;
    stateNext = state;
    unique case (state)
      S_FETCH_MAR: begin
        ctl.marFromPc = 1'b1;
        stateNext     = S_FETCH_INC;
      end
      S_FETCH_INC: begin
        ctl.pcInc = 1'b1;
        stateNext = S_FETCH_MBR;
      end
      S_FETCH_MBR: begin
        ctl.mbrFromMem = 1'b1;
        stateNext      = S_FETCH_IR;
      end
      S_FETCH_IR: begin
        ctl.irLoad = 1'b1;
        stateNext  = S_DECODE;
      end
      S_DECODE: begin
        if (isRead || isStore) begin
          ctl.marFromIr = 1'b1;
          stateNext     = S_OP_WAIT;
        end else if (isClr) begin
          ctl.d0Load = 1'b1;
          ctl.aluOp  = ALU_ZERO;
          stateNext  = S_FETCH_MAR;
        end else if (isJmp) begin
          ctl.pcLoad = 1'b1;
          stateNext  = S_FETCH_MAR;
        end else if (isHalt) begin
          stateNext = S_HALT;
        end else begin
          stateNext = S_FETCH_MAR;
        end
      end
      S_OP_WAIT: begin
        if (isStore) begin
          ctl.mbrFromD0 = 1'b1;
          stateNext     = S_ST_WRITE;
        end else begin
          stateNext = S_OP_MBR;
        end
      end
      S_OP_MBR: begin
        ctl.mbrFromMem = 1'b1;
        stateNext      = S_OP_ALU;
      end
      S_OP_ALU: begin
        ctl.d0Load = 1'b1;
        ctl.aluOp  = isAdd ? ALU_ADD : (isSub ? ALU_SUB : ALU_PASS);
        stateNext  = S_FETCH_MAR;
      end
      S_ST_WRITE: begin
        ctl.memWe = 1'b1;
        stateNext = S_FETCH_MAR;
      end
      S_HALT: stateNext = S_HALT;
      default: stateNext = S_FETCH_MAR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= S_FETCH_MAR;
    else     state <= stateNext;
  end

  assign halted = state == S_HALT;

  // R6: write enable lasts a single cycle
  a_r6_we_pulse: assert property (@(posedge clk) disable iff (rst)
    ctl.memWe |=> !ctl.memWe);

  // R9: halt holds until reset
  a_r9_halt_sticky: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  // R2: a fetched word reaches the instruction register two cycles after the PC step
  a_r2_fetch_order: assert property (@(posedge clk) disable iff (rst)
    ctl.pcInc |=> ctl.mbrFromMem);

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [DATA_W-1:0]   memRdata,
  output logic [DATA_W/2-1:0] memAddr,
  output logic [DATA_W-1:0]   memWdata,
  output logic                memWe,
  output logic                halted
);

  localparam int ADDR_W = DATA_W / 2;
  localparam int OPC_W  = DATA_W - ADDR_W;

  ctlStrobeS        ctl;
  logic [OPC_W-1:0] opcode;

  acc_control #(.OPC_W(OPC_W)) control (
    .clk    (clk),
    .rst    (rst),
    .opcode (opcode),
    .ctl    (ctl),
    .halted (halted)
  );

  acc_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .OPC_W(OPC_W)) datapath (
    .clk      (clk),
    .rst      (rst),
    .ctl      (ctl),
    .memRdata (memRdata),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .opcode   (opcode)
  );

  assign memWe = ctl.memWe;

  // R9: once halted, the bus is quiet and frozen
  a_r9_halt_quiet: assert property (@(posedge clk) disable iff (rst)
    halted |=> $stable(memAddr) && !memWe);

endmodule

// File: tb/acc_cpu_test.sv
module acc_cpu_test;

  localparam int DATA_W = 16;
  localparam int ADDR_W = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [DATA_W-1:0] memRdata;
  logic [ADDR_W-1:0] memAddr;
  logic [DATA_W-1:0] memWdata;
  logic              memWe;
  logic              halted;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  acc_cpu #(.DATA_W(DATA_W)) uut (
    .clk      (clk),
    .rst      (rst),
    .memRdata (memRdata),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .memWe    (memWe),
    .halted   (halted)
  );

  // synchronous single-port memory, one cycle read latency
  logic [DATA_W-1:0] mem [256];
  always @(posedge clk) begin
    if (memWe) mem[memAddr] <= memWdata;
    memRdata <= mem[memAddr];
  end

  typedef struct {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    string             tag;
  } wrItemS;

  wrItemS expQ[$];

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic expectWrite(input logic [7:0] a, input logic [15:0] d, input string tag);
    wrItemS it;
    it.addr = a;
    it.data = d;
    it.tag  = tag;
    expQ.push_back(it);
  endtask

  function automatic logic [15:0] instr(input logic [7:0] op, input logic [7:0] a);
    return {op, a};
  endfunction

  // monitor: every write is compared against the next expected item
  always @(negedge clk) begin
    if (!rst && memWe) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R9", "unexpected write addr", 32'(memAddr), 32'hffff_ffff);
      end else begin
        wrItemS it;
        it = expQ.pop_front();
        check(memAddr == it.addr, it.tag, "write addr", 32'(memAddr), 32'(it.addr));
        check(memWdata == it.data, it.tag, "write data", 32'(memWdata), 32'(it.data));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic runToHalt(input int expCycles, input string tag);
    int n = 0;
    while (n < 400) begin
      @(negedge clk);
      n++;
      if (n == 9 && expCycles > 20)
        check(memAddr == 8'h01, "R2", "second fetch address", 32'(memAddr), 32'h1);
      if (halted) break;
    end
    check(n == expCycles, tag, "cycles to halt", 32'(n), 32'(expCycles));
  endtask

  initial begin
    logic [ADDR_W-1:0] frozenAddr;
    // ---------- program A ----------
    rst = 1'b1;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    mem[0]  = instr(8'h03, 8'h80);   // LOAD
    mem[1]  = instr(8'h01, 8'h81);   // ADD
    mem[2]  = instr(8'h04, 8'h90);   // STORE
    mem[3]  = instr(8'h02, 8'h82);   // SUB
    mem[4]  = instr(8'h04, 8'h91);   // STORE
    mem[5]  = instr(8'h77, 8'h00);   // undefined -> no-op
    mem[6]  = instr(8'h04, 8'h92);   // STORE
    mem[7]  = instr(8'h05, 8'h00);   // CLR
    mem[8]  = instr(8'h04, 8'h93);   // STORE
    mem[9]  = instr(8'h06, 8'h0C);   // JMP
    mem[10] = instr(8'h04, 8'h94);   // skipped
    mem[11] = instr(8'hFF, 8'h00);   // skipped
    mem[12] = instr(8'h03, 8'h83);   // LOAD
    mem[13] = instr(8'h04, 8'h95);   // STORE
    mem[14] = instr(8'hFF, 8'h00);   // HALT
    mem[8'h80] = 16'hFFF0;
    mem[8'h81] = 16'h0020;
    mem[8'h82] = 16'h0030;
    mem[8'h83] = 16'h1234;
    expectWrite(8'h90, 16'h0010, "R3");
    expectWrite(8'h91, 16'hFFE0, "R4");
    expectWrite(8'h92, 16'hFFE0, "R10");
    expectWrite(8'h93, 16'h0000, "R7");
    expectWrite(8'h95, 16'h1234, "R5");
    repeat (3) @(negedge clk);
    check(memAddr == 8'h00, "R1", "address in reset", 32'(memAddr), 32'h0);
    check(memWe == 1'b0, "R1", "write enable in reset", 32'(memWe), 32'h0);
    check(halted == 1'b0, "R1", "halted in reset", 32'(halted), 32'h0);
    rst = 1'b0;
    // 8+8+7+8+7+5+7+5+7+5+8+7 = 82 cycles, then 5 for the HALT
    runToHalt(87, "R11");
    check(expQ.size() == 0, "R6", "writes left", 32'(expQ.size()), 32'h0);
    check(mem[8'h94] == 16'h0000, "R8", "skipped store target", 32'(mem[8'h94]), 32'h0);
    frozenAddr = memAddr;
    repeat (20) @(negedge clk);
    check(halted == 1'b1, "R9", "halted held", 32'(halted), 32'h1);
    check(memAddr == frozenAddr, "R9", "address frozen", 32'(memAddr), 32'(frozenAddr));

    // ---------- program B: reset clears halt and D0 ----------
    rst = 1'b1;
    @(negedge clk);
    check(halted == 1'b0, "R9", "halted cleared by reset", 32'(halted), 32'h0);
    for (int i = 0; i < 256; i++) mem[i] = '0;
    mem[0] = instr(8'h04, 8'hA0);    // STORE of the cleared D0
    mem[1] = instr(8'hFF, 8'h00);    // HALT
    mem[8'hA0] = 16'hBEEF;
    expectWrite(8'hA0, 16'h0000, "R1");
    @(negedge clk);
    rst = 1'b0;
    runToHalt(12, "R11");
    check(expQ.size() == 0, "R6", "writes left", 32'(expQ.size()), 32'h0);
    check(mem[8'hA0] == 16'h0000, "R6", "memory written", 32'(mem[8'hA0]), 32'h0);
    repeat (5) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule